// File: doc/BRIEF.md
# Display command decoder and status registers

This block sits behind the byte receiver of a serial-bus slave in a segment display controller. Each received byte arrives with a valid strobe. At the start of every bus transfer the receiver pulses `frame_start`, and the decoder then reads bytes as commands. Bit 7 of a command byte is the chain flag: 1 means another command follows, and 0 marks the last command. After the last command, every further byte of the transfer is display data and belongs to the RAM writer, so the decoder ignores it.

The decoder holds the controller's status registers:

- the display-data pointer, loaded by a two-byte command;
- the three-bit device-select subaddress;
- separate input and output bank selects;
- the blink frequency and blink mode.

Each bank select is also mapped to a four-lane RAM bit mask. In static drive a bank selects one RAM bit (bit 0 or bit 2). In 1:2 multiplex it selects a bit pair (bits 0–1 or bits 2–3).

The sequencer has three states:

- `ST_CMD`: the decoder waits for a command byte.
- `ST_PTR_ARG`: the decoder waits for the argument byte of a pointer load.
- `ST_DATA`: the command chain has ended, and bytes are not decoded.

Its transitions are:

- `ST_CMD` to `ST_PTR_ARG`: on a pointer opcode.
- `ST_CMD` to `ST_CMD`: on any other opcode with the chain flag set.
- `ST_CMD` to `ST_DATA`: on any other opcode with the chain flag clear.
- `ST_PTR_ARG` to `ST_CMD` or `ST_DATA`: on the argument byte, following the chain flag of the opcode byte.
- `ST_DATA` to `ST_DATA`: on every byte.
- Any state to `ST_CMD`: on `frame_start`.

Top module: `disp_cmd_dec`

## Requirements
- R1: While `rst` is high at a clock edge, all registers, both masks' bank inputs, `cmd_ack` and `data_phase` are cleared to zero on that edge and the sequencer returns to command phase.
- R2: A command byte with bits [6:4] = 000 is a pointer load; the next accepted byte supplies the pointer in bits [6:0] (its bit 7 is ignored) and `data_ptr` shows it one cycle after that byte.
- R3: A pointer argument above 79 loads 79 and sets `ptr_err`; `ptr_err` stays set until reset, and `data_ptr` never exceeds 79.
- R4: A command byte with bits [6:4] = 110 loads `dev_sub` from bits [2:0].
- R5: A command byte with bits [6:4] = 111 loads `bank_in` from bit 1 and `bank_out` from bit 0.
- R6: A command byte with bits [6:4] = 101 loads `blink_freq` from bits [1:0] (0 off, 1 = 2 Hz, 2 = 1 Hz, 3 = 0.5 Hz) and `blink_alt` from bit 2 (0 normal, 1 alternation).
- R7: Command bytes with bits [6:4] = 001, 010, 011 or 100 change no register, but are acknowledged and obey the chain flag.
- R8: Bit 7 of a command byte set keeps the decoder in command phase; clear moves it to data phase (`data_phase` = 1) after that command completes; bytes in data phase change no register and are not acknowledged.
- R9: `frame_start` returns the decoder to command phase from any state; a byte presented in the same cycle is ignored.
- R10: `cmd_ack` is high in exactly the cycle after each byte consumed as a command or pointer argument.
- R11: With `drive_mux2` = 0 a bank value b sets only mask bit 2b; with `drive_mux2` = 1 it sets bits 2b and 2b+1; this holds for both `in_ram_mask` and `out_ram_mask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse at start of each bus transfer |
| rx_valid | input | 1 | Byte strobe from the receiver |
| rx_byte | input | 8 | Received byte |
| drive_mux2 | input | 1 | 1 = 1:2 multiplex drive, 0 = static drive |
| cmd_ack | output | 1 | Byte consumed by the decoder (one cycle later) |
| data_phase | output | 1 | Command chain ended; bytes are display data |
| data_ptr | output | 7 | Display-data pointer |
| ptr_err | output | 1 | Sticky out-of-range pointer flag |
| dev_sub | output | 3 | Device-select subaddress |
| bank_in | output | 1 | Input bank select |
| bank_out | output | 1 | Output (displayed) bank select |
| in_ram_mask | output | 4 | RAM bits written for the input bank |
| out_ram_mask | output | 4 | RAM bits shown for the output bank |
| blink_freq | output | 2 | Blink frequency code |
| blink_alt | output | 1 | Blink mode, 1 = alternation |

## Verification
The assertions assume that `frame_start` and `rx_valid` are known after reset, and that the receiver never holds a byte waiting for acceptance. The decoder takes each strobe as one byte, so one cycle of `rx_valid` stands for exactly one received byte. The bench keeps to this by driving each byte for a single cycle, changing inputs only just after the clock edge. It also lets random `frame_start` pulses collide with byte strobes, since that collision is legal and its outcome is defined.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    typedef enum logic [1:0] {
        ST_CMD     = 2'd0,
        ST_PTR_ARG = 2'd1,
        ST_DATA    = 2'd2
    } dec_state_t;

    localparam logic [2:0] OP_PTR   = 3'b000;
    localparam logic [2:0] OP_BLINK = 3'b101;
    localparam logic [2:0] OP_SUB   = 3'b110;
    localparam logic [2:0] OP_BANK  = 3'b111;

    localparam int ARG_W = 7;

endpackage

// File: rtl/disp_cmd_fsm.sv
module disp_cmd_fsm
    import disp_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       rx_valid,
    input  logic [3:0] op_nib,
    output logic       ld_ptr,
    output logic       ld_sub,
    output logic       ld_bank,
    output logic       ld_blink,
    output logic       cmd_ack,
    output logic       data_phase
);

    dec_state_t state_q, state_d;
    logic       cont_q, cont_d;
    logic       take;
    logic [2:0] opc;

    assign opc  = op_nib[2:0];
    assign take = rx_valid && !frame_start && (state_q != ST_DATA);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CMD;
            cont_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cont_q  <= cont_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cont_d  = cont_q;
        if (frame_start) begin
            state_d = ST_CMD;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_CMD: begin
                    if (opc == OP_PTR) begin
                        state_d = ST_PTR_ARG;
                        cont_d  = op_nib[3];
                    end else begin
                        state_d = op_nib[3] ? ST_CMD : ST_DATA;
                    end
                end
                ST_PTR_ARG: state_d = cont_q ? ST_CMD : ST_DATA;
                ST_DATA:    state_d = ST_DATA;
                default:    state_d = ST_CMD;
            endcase
        end
    end

    // output decode
    always_comb begin
        ld_ptr     = take && (state_q == ST_PTR_ARG);
        ld_sub     = take && (state_q == ST_CMD) && (opc == OP_SUB);
        ld_bank    = take && (state_q == ST_CMD) && (opc == OP_BANK);
        ld_blink   = take && (state_q == ST_CMD) && (opc == OP_BLINK);
        data_phase = (state_q == ST_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_ack <= 1'b0;
        else     cmd_ack <= take;
    end

    p_ack_source_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |-> $past(rx_valid && !frame_start));

    p_data_no_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !frame_start) |=> !cmd_ack);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (state_q == ST_CMD));

endmodule

// File: rtl/disp_cmd_regs.sv
module disp_cmd_regs
    import disp_cmd_pkg::*;
#(
    parameter int PTR_W   = 7,
    parameter int PTR_MAX = 79,
    parameter int SUB_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_ptr,
    input  logic             ld_sub,
    input  logic             ld_bank,
    input  logic             ld_blink,
    input  logic [ARG_W-1:0] arg,
    output logic [PTR_W-1:0] data_ptr,
    output logic             ptr_err,
    output logic [SUB_W-1:0] dev_sub,
    output logic             bank_in,
    output logic             bank_out,
    output logic [1:0]       blink_freq,
    output logic             blink_alt
);

    localparam logic [ARG_W-1:0] LIMIT = ARG_W'(PTR_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_ptr   <= '0;
            ptr_err    <= 1'b0;
            dev_sub    <= '0;
            bank_in    <= 1'b0;
            bank_out   <= 1'b0;
            blink_freq <= 2'd0;
            blink_alt  <= 1'b0;
        end else begin
            if (ld_ptr) begin
                if (arg > LIMIT) begin
                    data_ptr <= PTR_W'(PTR_MAX);
                    ptr_err  <= 1'b1;
                end else begin
                    data_ptr <= PTR_W'(arg);
                end
            end
            if (ld_sub) dev_sub <= arg[SUB_W-1:0];
            if (ld_bank) begin
                bank_in  <= arg[1];
                bank_out <= arg[0];
            end
            if (ld_blink) begin
                blink_freq <= arg[1:0];
                blink_alt  <= arg[2];
            end
        end
    end

    p_ptr_limit_r3: assert property (@(posedge clk) disable iff (rst)
        data_ptr <= PTR_W'(PTR_MAX));

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ptr_err |=> ptr_err);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(ld_ptr || ld_sub || ld_bank || ld_blink) |=>
        $stable({data_ptr, dev_sub, bank_in, bank_out, blink_freq, blink_alt}));

endmodule

// File: rtl/disp_bank_map.sv
module disp_bank_map #(
    parameter int LANES = 4
) (
    input  logic             bank,
    input  logic             mux2,
    output logic [LANES-1:0] mask
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic HI   = (i >= LANES / 2);
        localparam logic EVEN = ((i % 2) == 0);
        assign mask[i] = (bank == HI) && (mux2 || EVEN);
    end

endmodule

// File: rtl/disp_cmd_dec.sv
module disp_cmd_dec
    import disp_cmd_pkg::*;
#(
    parameter int PTR_W   = 7,
    parameter int PTR_MAX = 79,
    parameter int SUB_W   = 3,
    parameter int LANES   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             drive_mux2,
    output logic             cmd_ack,
    output logic             data_phase,
    output logic [PTR_W-1:0] data_ptr,
    output logic             ptr_err,
    output logic [SUB_W-1:0] dev_sub,
    output logic             bank_in,
    output logic             bank_out,
    output logic [LANES-1:0] in_ram_mask,
    output logic [LANES-1:0] out_ram_mask,
    output logic [1:0]       blink_freq,
    output logic             blink_alt
);

    logic ld_ptr, ld_sub, ld_bank, ld_blink;

    disp_cmd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .rx_valid   (rx_valid),
        .op_nib     (rx_byte[7:4]),
        .ld_ptr     (ld_ptr),
        .ld_sub     (ld_sub),
        .ld_bank    (ld_bank),
        .ld_blink   (ld_blink),
        .cmd_ack    (cmd_ack),
        .data_phase (data_phase)
    );

    disp_cmd_regs #(
        .PTR_W  (PTR_W),
        .PTR_MAX(PTR_MAX),
        .SUB_W  (SUB_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ld_ptr    (ld_ptr),
        .ld_sub    (ld_sub),
        .ld_bank   (ld_bank),
        .ld_blink  (ld_blink),
        .arg       (rx_byte[ARG_W-1:0]),
        .data_ptr  (data_ptr),
        .ptr_err   (ptr_err),
        .dev_sub   (dev_sub),
        .bank_in   (bank_in),
        .bank_out  (bank_out),
        .blink_freq(blink_freq),
        .blink_alt (blink_alt)
    );

    disp_bank_map #(.LANES(LANES)) u_map_in (
        .bank(bank_in),
        .mux2(drive_mux2),
        .mask(in_ram_mask)
    );

    disp_bank_map #(.LANES(LANES)) u_map_out (
        .bank(bank_out),
        .mux2(drive_mux2),
        .mask(out_ram_mask)
    );

    p_mask_width_r11: assert property (@(posedge clk) disable iff (rst)
        ($countones(in_ram_mask) == (drive_mux2 ? 2 : 1)) &&
        ($countones(out_ram_mask) == (drive_mux2 ? 2 : 1)));

endmodule

// File: tb/disp_cmd_dec_tb.sv
module disp_cmd_dec_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       drive_mux2 = 1'b0;

    logic       cmd_ack, data_phase, ptr_err, bank_in, bank_out, blink_alt;
    logic [6:0] data_ptr;
    logic [2:0] dev_sub;
    logic [3:0] in_ram_mask, out_ram_mask;
    logic [1:0] blink_freq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit armed = 1'b0;

    always #4 clk = ~clk;

    disp_cmd_dec dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .drive_mux2(drive_mux2), .cmd_ack(cmd_ack),
        .data_phase(data_phase), .data_ptr(data_ptr), .ptr_err(ptr_err),
        .dev_sub(dev_sub), .bank_in(bank_in), .bank_out(bank_out),
        .in_ram_mask(in_ram_mask), .out_ram_mask(out_ram_mask),
        .blink_freq(blink_freq), .blink_alt(blink_alt)
    );

    // behavioural model: phase 0 = commands, 1 = pointer argument, 2 = data
    int m_phase, m_cont, m_ptr, m_err, m_sub, m_bin, m_bout, m_freq, m_alt, m_ack;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cont = 0; m_ptr = 0; m_err = 0; m_sub = 0;
            m_bin = 0; m_bout = 0; m_freq = 0; m_alt = 0; m_ack = 0;
            armed = 1'b1;
        end else begin
            m_ack = 0;
            if (frame_start) begin
                m_phase = 0;
            end else if (rx_valid) begin
                if (m_phase == 0) begin
                    int op;
                    op = (rx_byte >> 4) & 7;
                    m_ack = 1;
                    if (op == 0) begin
                        m_phase = 1;
                        m_cont = rx_byte[7];
                    end else begin
                        if (op == 6) m_sub = rx_byte & 7;
                        if (op == 7) begin m_bin = rx_byte[1]; m_bout = rx_byte[0]; end
                        if (op == 5) begin m_freq = rx_byte & 3; m_alt = rx_byte[2]; end
                        m_phase = rx_byte[7] ? 0 : 2;
                    end
                end else if (m_phase == 1) begin
                    int v;
                    v = rx_byte & 127;
                    m_ack = 1;
                    if (v > 79) begin m_ptr = 79; m_err = 1; end
                    else m_ptr = v;
                    m_phase = m_cont ? 0 : 2;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mask_of(input int bank, input int mux2);
        return (mux2 ? 3 : 1) << (2 * bank);
    endfunction

    always @(negedge clk) begin
        if (armed && !finished) begin
            chk("R2 data_ptr", data_ptr, m_ptr);
            chk("R3 ptr_err", ptr_err, m_err);
            chk("R4 dev_sub", dev_sub, m_sub);
            chk("R5 bank_in", bank_in, m_bin);
            chk("R5 bank_out", bank_out, m_bout);
            chk("R6 blink_freq", blink_freq, m_freq);
            chk("R6 blink_alt", blink_alt, m_alt);
            chk("R8 data_phase", data_phase, (m_phase == 2) ? 1 : 0);
            chk("R10 cmd_ack", cmd_ack, m_ack);
            chk("R11 in_ram_mask", in_ram_mask, mask_of(m_bin, drive_mux2));
            chk("R11 out_ram_mask", out_ram_mask, mask_of(m_bout, drive_mux2));
        end
    end

    task automatic send(input logic [7:0] b, input logic fs);
        @(posedge clk); #2;
        rx_valid = 1'b1; rx_byte = b; frame_start = fs;
    endtask

    task automatic restart();
        @(posedge clk); #2;
        rx_valid = 1'b0; frame_start = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            rx_valid = 1'b0; frame_start = 1'b0;
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 data_ptr", data_ptr, 0);
        chk("R1 ptr_err", ptr_err, 0);
        chk("R1 dev_sub", dev_sub, 0);
        chk("R1 blink", {blink_alt, blink_freq}, 0);
        chk("R1 cmd_ack", cmd_ack, 0);
        chk("R1 data_phase", data_phase, 0);
        @(posedge clk); #2; rst = 1'b0;

        // chained commands: pointer 5, subaddress 5, in=1 out=0, blink alt 1 Hz (last)
        restart();
        send(8'h80, 1'b0); send(8'h05, 1'b0);
        send(8'hE5, 1'b0); send(8'hF2, 1'b0); send(8'h56, 1'b0);
        send(8'h80, 1'b0); send(8'hE7, 1'b0);   // data phase, ignored
        idle(1);
        @(negedge clk);
        chk("R8 data bytes ignored sub", dev_sub, 5);
        chk("R8 data bytes ignored ptr", data_ptr, 5);
        chk("R8 in data phase", data_phase, 1);

        // R3 clamp: single pointer load, last command
        restart();
        send(8'h00, 1'b0); send(8'h7F, 1'b0);
        idle(1);
        @(negedge clk);
        chk("R3 clamp", data_ptr, 79);
        chk("R3 err set", ptr_err, 1);

        // R7 unknown opcodes, then bank select in=0 out=1 (last)
        restart();
        send(8'h90, 1'b0); send(8'hA3, 1'b0); send(8'hB7, 1'b0); send(8'hC1, 1'b0);
        idle(1);
        @(negedge clk);
        chk("R7 sub unchanged", dev_sub, 5);
        chk("R7 freq unchanged", blink_freq, 2);
        chk("R7 ptr unchanged", data_ptr, 79);
        chk("R7 still command phase", data_phase, 0);
        send(8'h71, 1'b0);
        idle(2);
        drive_mux2 = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R11 mux2 out mask", out_ram_mask, 4'b1100);
        chk("R11 mux2 in mask", in_ram_mask, 4'b0011);

        // R9 byte colliding with frame_start is dropped
        send(8'hE3, 1'b1);
        idle(1);
        @(negedge clk);
        chk("R9 collided byte ignored", dev_sub, 5);
        chk("R9 command phase", data_phase, 0);

        // R2 argument bit 7 ignored; chain continues
        send(8'h80, 1'b0); send(8'hB0, 1'b0);
        idle(1);
        @(negedge clk);
        chk("R2 arg bit7 ignored", data_ptr, 48);
        chk("R3 err sticky", ptr_err, 1);
        chk("R2 chain continues", data_phase, 0);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #2;
            frame_start = ($urandom % 12) == 0;
            rx_valid = ($urandom % 3) != 0;
            rx_byte = 8'($urandom);
            if (($urandom % 40) == 0) drive_mux2 = ~drive_mux2;
        end
        idle(1);

        // R1 reset mid-run
        @(posedge clk); #2; rst = 1'b1;
        idle(1);
        @(negedge clk);
        chk("R1 mid-run ptr", data_ptr, 0);
        chk("R1 mid-run err", ptr_err, 0);
        chk("R1 mid-run phase", data_phase, 0);
        @(posedge clk); #2; rst = 1'b0;
        idle(3);
        summary();
    end

endmodule